// File: doc/BRIEF.md
# Seconds-of-day to BCD time converter

This block converts in both directions between a binary seconds count and a packed BCD time word holding hours, minutes and seconds. The forward path takes any seconds value of the configured width and folds it into a single day before it splits the result into three two-digit BCD fields. The reverse path takes a packed time word and expands it into a binary seconds count. Neither path uses a divider. Every division by a constant is done as a multiply by a rounded-up reciprocal followed by a right shift.

Each direction has its own valid/ready pair on the input side and on the output side, and each has its own one-entry result register. A result is presented one cycle after its input is accepted. While the consumer stalls, the result is held. The two paths are independent and can run concurrently, so a forward result can be fed straight into the reverse input.

Top module: `sec_bcd_conv`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both output valids are low and both input readies are high.
- R2: The forward result encodes the input seconds value reduced modulo 86400, so that an input of 86400 or more wraps to the matching time of day.
- R3: Within the day, hours are the seconds divided by 3600, minutes are the remainder divided by 60, and seconds are the last remainder. Each is packed as a tens digit and a units digit: seconds units in bits 3:0 and tens in bits 6:4, minutes units in bits 11:8 and tens in bits 14:12, hours units in bits 19:16 and tens in bits 21:20.
- R4: Bits 7, 15 and 31:22 of the forward result are always zero.
- R5: The reverse result is (hour tens·10 + hour units)·3600 + (minute tens·10 + minute units)·60 + seconds tens·10 + seconds units, using the field positions of R3. A digit above 9 enters this sum with its plain binary value.
- R6: On the reverse input, bits 7, 15 and 31:22 have no effect on the result.
- R7: While an output valid is high and its ready is low, that output keeps its valid high and its data unchanged.
- R8: An input ready is high exactly when its output register is empty or being read in the same cycle. An accepted input makes its output valid high on the next cycle, and results leave in the order their inputs were accepted.
- R9: Feeding any forward result back through the reverse path returns the original seconds value modulo 86400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s2t_in_valid | input | 1 | Forward input valid |
| s2t_in_ready | output | 1 | Forward input ready |
| s2t_in_sec | input | SEC_W | Seconds value to convert |
| s2t_out_valid | output | 1 | Forward result valid |
| s2t_out_ready | input | 1 | Forward result taken |
| s2t_out_time | output | 32 | Packed BCD time word |
| t2s_in_valid | input | 1 | Reverse input valid |
| t2s_in_ready | output | 1 | Reverse input ready |
| t2s_in_time | input | 32 | Packed BCD time word to expand |
| t2s_out_valid | output | 1 | Reverse result valid |
| t2s_out_ready | input | 1 | Reverse result taken |
| t2s_out_sec | output | SEC_W | Binary seconds result |

## Verification
The bench sweeps every second of the day through the forward path and chains each forward result into the reverse path, with the padding bits forced high. A wrong reciprocal or a wrong shift would show up as an off-by-one digit near the ends of a range, such as 59→60 or 3599→3600. Padding that leaks would show up as a wrong seconds count. Wrap values such as 86400, 172799 and the all-ones word target the day fold: a fold that is exact only for small inputs would give a wrong hour there. A directed pass with ready toggling checks that a stalled result is held and is not overwritten by the next input. A design that dropped or reordered a result under backpressure would leave an expectation unmatched.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   // packed time word
   localparam int TW          = 32;
   localparam int FIELD_STEP  = 8;
   localparam int SEC_LO      = 0;
   localparam int MIN_LO      = 8;
   localparam int HR_LO       = 16;
   localparam int TENS_OFS    = 4;
   localparam logic [TW-1:0] DIGIT_MASK = 32'h003F_7F7F;
   // day fold: 86400 = 675 * 2^7
   localparam int DAY_LOW_BITS = 7;
   localparam int DAY_HI_DIV   = 675;
   // largest reverse result (non-decimal digits included)
   localparam int REV_MAX      = 167185;
   // legal range for the seconds width
   localparam int SEC_W_MIN    = 18;
   localparam int SEC_W_MAX    = 32;
endpackage

// File: rtl/sbc_recip_div.sv
// Constant divider: floor(num / DIV) by reciprocal multiply and shift.
// The result is exact when IN_W + clog2(DIV) <= SHIFT.
module sbc_recip_div #(
   parameter int IN_W  = 8,
   parameter int DIV   = 10,
   parameter int SHIFT = 19,
   parameter int Q_W   = 4
) (
   input  logic [IN_W-1:0] num,
   output logic [Q_W-1:0]  quo
);
   localparam bit IS_POW2 = ((DIV & (DIV - 1)) == 0);
   localparam int DIV_W   = $clog2(DIV);

   if (DIV < 2) begin : g_bad_div
      $error("sbc_recip_div: DIV must be at least 2");
   end

   if (IS_POW2) begin : g_shift
      assign quo = Q_W'(num >> DIV_W);
   end else begin : g_recip
      localparam int P_W = IN_W + SHIFT + 1;
      localparam logic [63:0] RECIP =
         ((64'd1 << SHIFT) + 64'(DIV) - 64'd1) / 64'(DIV);
      if (IN_W + DIV_W > SHIFT) begin : g_bad_shift
         $error("sbc_recip_div: SHIFT too small for exact quotient");
      end
      if (P_W > 64) begin : g_bad_pw
         $error("sbc_recip_div: product wider than 64 bits");
      end
      assign quo = Q_W'((P_W'(num) * P_W'(RECIP)) >> SHIFT);
   end
endmodule

// File: rtl/sbc_fwd.sv
// Seconds -> packed BCD time, combinational.
module sbc_fwd
   import sbc_pkg::*;
#(
   parameter int SEC_W = 32
) (
   input  logic [SEC_W-1:0] sec_in,
   output logic [TW-1:0]    time_out
);
   localparam int HI_W  = SEC_W - DAY_LOW_BITS;
   localparam int HQ_W  = HI_W + 10;
   localparam int SOD_W = 17;

   // fold into one day: keep the low 7 bits, reduce the rest mod 675
   logic [HI_W-1:0]  hi_quo;
   logic [9:0]       hi_rem;
   logic [SOD_W-1:0] sod;

   sbc_recip_div #(.IN_W(HI_W), .DIV(DAY_HI_DIV), .SHIFT(HI_W + 10), .Q_W(HI_W))
      u_day (.num(sec_in[SEC_W-1:DAY_LOW_BITS]), .quo(hi_quo));

   assign hi_rem = 10'(HQ_W'(sec_in[SEC_W-1:DAY_LOW_BITS])
                       - HQ_W'(HQ_W'(hi_quo) * HQ_W'(DAY_HI_DIV)));
   assign sod    = {hi_rem, sec_in[DAY_LOW_BITS-1:0]};

   // hours: (sod/16)/225
   logic [4:0]  hours;
   logic [11:0] rem_h;
   sbc_recip_div #(.IN_W(13), .DIV(225), .SHIFT(21), .Q_W(5))
      u_hr (.num(sod[SOD_W-1:4]), .quo(hours));
   assign rem_h = 12'(sod - SOD_W'(SOD_W'(hours) * SOD_W'(3600)));

   // minutes: (rem/4)/15
   logic [5:0] mins;
   logic [5:0] secs;
   sbc_recip_div #(.IN_W(10), .DIV(15), .SHIFT(14), .Q_W(6))
      u_min (.num(rem_h[11:2]), .quo(mins));
   assign secs = 6'(rem_h - 12'(12'(mins) * 12'd60));

   // three two-digit BCD fields
   for (genvar f = 0; f < 3; f++) begin : g_field
      localparam int LO  = f * FIELD_STEP;
      localparam int TQW = (f == 2) ? 2 : 3;
      logic [6:0]     val;
      logic [TQW-1:0] tens;
      logic [3:0]     units;

      if (f == 0) begin : g_s
         assign val = 7'(secs);
      end else if (f == 1) begin : g_m
         assign val = 7'(mins);
      end else begin : g_h
         assign val = 7'(hours);
      end

      sbc_recip_div #(.IN_W(7), .DIV(10), .SHIFT(19), .Q_W(TQW))
         u_d10 (.num(val), .quo(tens));
      assign units = 4'(val - 7'(7'(tens) * 7'd10));

      assign time_out[LO+3:LO]                           = units;
      assign time_out[LO+TENS_OFS+TQW-1:LO+TENS_OFS]     = tens;
      if (f < 2) begin : g_pad
         assign time_out[LO+7] = 1'b0;
      end
   end
   assign time_out[TW-1:22] = '0;
endmodule

// File: rtl/sbc_rev.sv
// Packed BCD time -> seconds, combinational.
module sbc_rev
   import sbc_pkg::*;
#(
   parameter int SEC_W = 32
) (
   input  logic [TW-1:0]    time_in,
   output logic [SEC_W-1:0] sec_out
);
   logic [5:0] hv;
   logic [6:0] mv;
   logic [6:0] sv;
   logic       unused_pad;

   assign hv = 6'(6'(time_in[HR_LO+5:HR_LO+4]) * 6'd10) + 6'(time_in[HR_LO+3:HR_LO]);
   assign mv = 7'(7'(time_in[MIN_LO+6:MIN_LO+4]) * 7'd10) + 7'(time_in[MIN_LO+3:MIN_LO]);
   assign sv = 7'(7'(time_in[SEC_LO+6:SEC_LO+4]) * 7'd10) + 7'(time_in[SEC_LO+3:SEC_LO]);

   assign sec_out = SEC_W'(18'(18'(hv) * 18'd3600) + 18'(18'(mv) * 18'd60) + 18'(sv));

   // padding bits do not take part in the result
   assign unused_pad = ^{time_in[TW-1:22], time_in[15], time_in[7]};
endmodule

// File: rtl/sbc_hold_reg.sv
// One-entry result register with valid/ready on both sides.
module sbc_hold_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end
endmodule

// File: rtl/sec_bcd_conv.sv
module sec_bcd_conv
   import sbc_pkg::*;
#(
   parameter int SEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s2t_in_valid,
   output logic             s2t_in_ready,
   input  logic [SEC_W-1:0] s2t_in_sec,
   output logic             s2t_out_valid,
   input  logic             s2t_out_ready,
   output logic [TW-1:0]    s2t_out_time,
   input  logic             t2s_in_valid,
   output logic             t2s_in_ready,
   input  logic [TW-1:0]    t2s_in_time,
   output logic             t2s_out_valid,
   input  logic             t2s_out_ready,
   output logic [SEC_W-1:0] t2s_out_sec
);
   if (SEC_W < SEC_W_MIN || SEC_W > SEC_W_MAX) begin : g_bad_w
      $error("sec_bcd_conv: SEC_W out of range");
   end

   logic [TW-1:0]    fwd_time;
   logic [SEC_W-1:0] rev_sec;

   sbc_fwd #(.SEC_W(SEC_W)) u_fwd (.sec_in(s2t_in_sec), .time_out(fwd_time));
   sbc_rev #(.SEC_W(SEC_W)) u_rev (.time_in(t2s_in_time), .sec_out(rev_sec));

   sbc_hold_reg #(.W(TW)) u_fwd_q (
      .clk(clk), .rst_n(rst_n),
      .in_valid(s2t_in_valid), .in_ready(s2t_in_ready), .in_data(fwd_time),
      .out_valid(s2t_out_valid), .out_ready(s2t_out_ready), .out_data(s2t_out_time));

   sbc_hold_reg #(.W(SEC_W)) u_rev_q (
      .clk(clk), .rst_n(rst_n),
      .in_valid(t2s_in_valid), .in_ready(t2s_in_ready), .in_data(rev_sec),
      .out_valid(t2s_out_valid), .out_ready(t2s_out_ready), .out_data(t2s_out_sec));
endmodule

// File: rtl/sbc_chk.sv
module sbc_chk
   import sbc_pkg::*;
#(
   parameter int SEC_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             s2t_in_valid,
   input logic             s2t_in_ready,
   input logic             s2t_out_valid,
   input logic             s2t_out_ready,
   input logic [TW-1:0]    s2t_out_time,
   input logic             t2s_in_valid,
   input logic             t2s_in_ready,
   input logic             t2s_out_valid,
   input logic             t2s_out_ready,
   input logic [SEC_W-1:0] t2s_out_sec
);
   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> !s2t_out_valid && !t2s_out_valid);

   // R7
   fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s2t_out_valid && !s2t_out_ready |=> s2t_out_valid && $stable(s2t_out_time));

   // R7
   rev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t2s_out_valid && !t2s_out_ready |=> t2s_out_valid && $stable(t2s_out_sec));

   // R8
   fwd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s2t_in_valid && s2t_in_ready |=> s2t_out_valid);

   // R8
   rev_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t2s_in_valid && t2s_in_ready |=> t2s_out_valid);

   // R4
   fwd_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s2t_out_valid |-> (s2t_out_time & ~DIGIT_MASK) == '0);

   // R3
   fwd_digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s2t_out_valid |-> s2t_out_time[3:0] <= 4'd9 && s2t_out_time[6:4] <= 3'd5
         && s2t_out_time[11:8] <= 4'd9 && s2t_out_time[14:12] <= 3'd5
         && (s2t_out_time[21:20] == 2'd2 ? s2t_out_time[19:16] <= 4'd3
                                         : s2t_out_time[21:20] < 2'd2 && s2t_out_time[19:16] <= 4'd9));

   // R5
   rev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t2s_out_valid |-> t2s_out_sec <= SEC_W'(REV_MAX));
endmodule

bind sec_bcd_conv sbc_chk #(.SEC_W(SEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .s2t_in_valid(s2t_in_valid), .s2t_in_ready(s2t_in_ready),
   .s2t_out_valid(s2t_out_valid), .s2t_out_ready(s2t_out_ready),
   .s2t_out_time(s2t_out_time),
   .t2s_in_valid(t2s_in_valid), .t2s_in_ready(t2s_in_ready),
   .t2s_out_valid(t2s_out_valid), .t2s_out_ready(t2s_out_ready),
   .t2s_out_sec(t2s_out_sec));

// File: tb/sec_bcd_conv_tb.sv
module sec_bcd_conv_tb;
   localparam int SEC_W = 32;
   localparam logic [31:0] JUNK = 32'hFFC0_8080;

   logic clk = 1'b0;
   logic rst_n;
   always #5 clk = ~clk;

   logic        s2t_in_valid, s2t_in_ready, s2t_out_valid, s2t_out_ready;
   logic [31:0] s2t_in_sec, s2t_out_time;
   logic        t2s_in_valid, t2s_in_ready, t2s_out_valid, t2s_out_ready;
   logic [31:0] t2s_in_time, t2s_out_sec;

   sec_bcd_conv #(.SEC_W(SEC_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .s2t_in_valid(s2t_in_valid), .s2t_in_ready(s2t_in_ready), .s2t_in_sec(s2t_in_sec),
      .s2t_out_valid(s2t_out_valid), .s2t_out_ready(s2t_out_ready), .s2t_out_time(s2t_out_time),
      .t2s_in_valid(t2s_in_valid), .t2s_in_ready(t2s_in_ready), .t2s_in_time(t2s_in_time),
      .t2s_out_valid(t2s_out_valid), .t2s_out_ready(t2s_out_ready), .t2s_out_sec(t2s_out_sec));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   bit mon_on = 0;

   logic [31:0] fq[$], rq[$], fin_q[$], rin_q[$];
   logic [31:0] f_exp_next, r_exp_next, f_held, r_held, e;
   bit f_hold, r_hold, f_acc, r_acc;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // behavioural forward reference
   function automatic logic [31:0] ref_time(input logic [31:0] x);
      int unsigned s, h, m, c;
      s = x % 32'd86400;
      h = s / 3600;
      m = (s % 3600) / 60;
      c = s % 60;
      ref_time = '0;
      ref_time[21:20] = 2'(h / 10);
      ref_time[19:16] = 4'(h % 10);
      ref_time[14:12] = 3'(m / 10);
      ref_time[11:8]  = 4'(m % 10);
      ref_time[6:4]   = 3'(c / 10);
      ref_time[3:0]   = 4'(c % 10);
   endfunction

   // behavioural reverse reference
   function automatic logic [31:0] ref_sec(input logic [31:0] w);
      ref_sec = (32'(w[21:20]) * 10 + 32'(w[19:16])) * 3600
              + (32'(w[14:12]) * 10 + 32'(w[11:8])) * 60
              + 32'(w[6:4]) * 10 + 32'(w[3:0]);
   endfunction

   // per-cycle monitor, sampling at the falling edge
   always @(negedge clk) begin
      if (mon_on) begin
         if (f_hold) check(s2t_out_valid && s2t_out_time == f_held, "R7 fwd hold", s2t_out_time, f_held);
         if (r_hold) check(t2s_out_valid && t2s_out_sec == r_held, "R7 rev hold", t2s_out_sec, r_held);
         check(s2t_in_ready == (!s2t_out_valid || s2t_out_ready), "R8 fwd ready",
               32'(s2t_in_ready), 32'(!s2t_out_valid || s2t_out_ready));
         check(t2s_in_ready == (!t2s_out_valid || t2s_out_ready), "R8 rev ready",
               32'(t2s_in_ready), 32'(!t2s_out_valid || t2s_out_ready));
         if (f_acc) check(s2t_out_valid, "R8 fwd latency", 32'(s2t_out_valid), 32'd1);
         if (r_acc) check(t2s_out_valid, "R8 rev latency", 32'(t2s_out_valid), 32'd1);
         if (s2t_out_valid && s2t_out_ready) begin
            if (fq.size() == 0) check(1'b0, "R8 fwd extra result", s2t_out_time, 32'd0);
            else begin
               e = fq.pop_front();
               check(s2t_out_time == e, "R2 R3 fwd value", s2t_out_time, e);
               check((s2t_out_time & JUNK) == 0, "R4 pad bits", s2t_out_time & JUNK, 32'd0);
            end
         end
         if (t2s_out_valid && t2s_out_ready) begin
            if (rq.size() == 0) check(1'b0, "R8 rev extra result", t2s_out_sec, 32'd0);
            else begin
               e = rq.pop_front();
               check(t2s_out_sec == e, "R5 R6 R9 rev value", t2s_out_sec, e);
            end
         end
         if (s2t_in_valid && s2t_in_ready) fq.push_back(f_exp_next);
         if (t2s_in_valid && t2s_in_ready) rq.push_back(r_exp_next);
         f_hold = s2t_out_valid && !s2t_out_ready;
         r_hold = t2s_out_valid && !t2s_out_ready;
         f_held = s2t_out_time;
         r_held = t2s_out_sec;
         f_acc  = s2t_in_valid && s2t_in_ready;
         r_acc  = t2s_in_valid && t2s_in_ready;
      end
   end

   task automatic run_directed(input bit bp);
      int cyc = 0;
      while (fin_q.size() > 0 || rin_q.size() > 0 || s2t_in_valid || t2s_in_valid) begin
         @(posedge clk); #1;
         cyc++;
         if (s2t_in_valid && f_acc) s2t_in_valid = 1'b0;
         if (t2s_in_valid && r_acc) t2s_in_valid = 1'b0;
         if (!s2t_in_valid && fin_q.size() > 0) begin
            s2t_in_sec   = fin_q.pop_front();
            f_exp_next   = ref_time(s2t_in_sec);
            s2t_in_valid = 1'b1;
         end
         if (!t2s_in_valid && rin_q.size() > 0) begin
            t2s_in_time  = rin_q.pop_front();
            r_exp_next   = ref_sec(t2s_in_time);
            t2s_in_valid = 1'b1;
         end
         s2t_out_ready = bp ? (cyc % 5 < 2) : 1'b1;
         t2s_out_ready = bp ? (cyc % 3 != 0) : 1'b1;
      end
      s2t_out_ready = 1'b1;
      t2s_out_ready = 1'b1;
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic load_lists();
      // R2 wrap values and field boundaries
      fin_q = {32'd86400, 32'd86401, 32'd90061, 32'd172799, 32'hFFFF_FFFF,
               32'h8000_0000, 32'd1000000, 32'd3599, 32'd3600, 32'd59, 32'd60};
      // R5 R6: padding set, max digits, non-decimal digit
      rin_q = {32'h0023_5959, 32'hFFE3_D9D9, 32'hFFC0_8080, 32'h0000_000F,
               32'h003F_7F7F, 32'h0012_3456, 32'h8012_B456};
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd190000, 32'd0);
      report();
   end

   initial begin
      rst_n = 1'b0;
      s2t_in_valid = 1'b0; s2t_out_ready = 1'b0; s2t_in_sec = '0;
      t2s_in_valid = 1'b0; t2s_out_ready = 1'b0; t2s_in_time = '0;
      f_exp_next = '0; r_exp_next = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(!s2t_out_valid, "R1 fwd valid in reset", 32'(s2t_out_valid), 32'd0);
      check(!t2s_out_valid, "R1 rev valid in reset", 32'(t2s_out_valid), 32'd0);
      check(s2t_in_ready, "R1 fwd ready in reset", 32'(s2t_in_ready), 32'd1);
      check(t2s_in_ready, "R1 rev ready in reset", 32'(t2s_in_ready), 32'd1);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(!s2t_out_valid && !t2s_out_valid, "R1 idle after release",
            32'({s2t_out_valid, t2s_out_valid}), 32'd0);
      mon_on = 1'b1;

      // full-day sweep, forward result chained into reverse (R9)
      s2t_out_ready = 1'b1;
      t2s_out_ready = 1'b1;
      for (int s = 0; s <= 86400; s++) begin
         @(posedge clk); #1;
         t2s_in_valid = s2t_out_valid;
         t2s_in_time  = s2t_out_time | JUNK;
         r_exp_next   = 32'(s - 1);
         if (s < 86400) begin
            s2t_in_valid = 1'b1;
            s2t_in_sec   = 32'(s);
            f_exp_next   = ref_time(32'(s));
         end else begin
            s2t_in_valid = 1'b0;
         end
      end
      @(posedge clk); #1;
      t2s_in_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1;

      load_lists();
      run_directed(1'b0);
      load_lists();
      run_directed(1'b1);   // R7 under backpressure

      check(fq.size() == 0, "R8 fwd results delivered", 32'(fq.size()), 32'd0);
      check(rq.size() == 0, "R8 rev results delivered", 32'(rq.size()), 32'd0);
      report();
   end
endmodule